// File: doc/BRIEF.md
# Multi-Source Reset Controller with Sticky Cause Register

This block merges the reset requests of a mixed-signal chip into two outputs. One is an active-low drive enable for a shared open-drain reset pin. The other is a reset for the local register bank. It takes four internal request levels: power-on (asynchronous), supply low voltage, over-temperature and watchdog. It also samples the level of the reset pin, so that an outside agent pulling the pin low is seen as an external reset. Every internal request holds the pin low while it lasts. A counter then keeps the pin low for a further fixed number of clock cycles, which the integrator derives from the clock frequency to reach roughly 1.25 ms.

Software reads the cause of the last resets from a sticky five-bit cause register and clears each flag by writing a one to it. The cause register survives every reset except power-on. A one-bit control register lets software mask the over-temperature reset. Because that control bit lives in the register bank, any bank reset clears it.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_req` is high, `rst_pin_oe` and `bank_rst` are high. The cause register reads 0x01 (only the power-on flag, bit 0) and the control register reads 0. After `por_req` falls, the pin stays driven for exactly `STRETCH_CYC` clock cycles.
- R2: A low-voltage request sets cause bit 1 and a watchdog request sets cause bit 3. From the next rising edge, and for as long as the request is active, `rst_pin_oe` and `bank_rst` are high.
- R3: After the last internal request is sampled low, `rst_pin_oe` stays high for exactly `STRETCH_CYC` cycles. Requests that overlap or follow each other restart this count.
- R4: With control bit 0 (over-temperature mask) at 0, an over-temperature request sets cause bit 2 and acts like R2. With the mask at 1 and no other reset active, the request sets no flag and does not drive the pin or `bank_rst`.
- R5: A low level on `rst_pin_i` while the block is not driving the pin sets cause bit 4 and raises `bank_rst` three rising edges later. It does not raise `rst_pin_oe`.
- R6: The block's own pin drive, including the two cycles after it releases the pin, never sets cause bit 4.
- R7: Writing to address 0 clears each cause bit that is written with one. Bits written with zero are left unchanged.
- R8: A low-voltage, watchdog, over-temperature or external reset keeps the cause register but clears the control register. This re-enables the over-temperature reset.
- R9: When several internal causes are active together, all of their cause bits are set.
- R10: Reads are combinational: address 0 returns the cause register and address 1 returns the mask in bit 0. A write to address 1 sets the mask only while no bank reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request, asynchronous, active high |
| lvr_req | input | 1 | Supply low-voltage request |
| htr_req | input | 1 | Over-temperature request |
| wdr_req | input | 1 | Watchdog reset request |
| rst_pin_i | input | 1 | Sampled level of the open-drain reset pin |
| rst_pin_oe | output | 1 | High pulls the reset pin low |
| bank_rst | output | 1 | Reset for the register bank |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 cause, 1 control) |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Read data |

## Verification
Three kinds of internal fault show up at the ports. A wrong stretch count shows as a pin pulse whose length differs from `STRETCH_CYC`, one cycle after release. A bad synchronizer blanking window shows as a stray cause bit 4 within three cycles of a pin release. A flag that is cleared or set wrongly shows at the next read of address 0. The bench sweeps every combination of the three internal requests with the mask both off and on. After each case it measures the pulse length and reads both registers back.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int CAUSE_W = 5;
    localparam int C_POR   = 0;
    localparam int C_LVR   = 1;
    localparam int C_HTR   = 2;
    localparam int C_WDR   = 3;
    localparam int C_PIN   = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_AFTER_POR = CAUSE_W'(1) << C_POR;
endpackage

// File: rtl/rcc_pin_sync.sv
module rcc_pin_sync (
    input  logic clk,
    input  logic por_req,
    input  logic pin_i,
    input  logic drive_i,
    output logic ext_o,
    output logic ext_now_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic [1:0] blank;
        logic       ext;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync  = {st_q.sync[0], pin_i};
        st_d.blank = {st_q.blank[0], drive_i};
        ext_now_o  = ~st_q.sync[1] & ~drive_i & ~(|st_q.blank);
        st_d.ext   = ext_now_o;
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) st_q <= '{sync: 2'b11, blank: 2'b11, ext: 1'b0};
        else         st_q <= st_d;
    end

    assign ext_o = st_q.ext;
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
    parameter int STRETCH_CYC = 20000
) (
    input  logic clk,
    input  logic por_req,
    input  logic evt_i,
    output logic drive_o
);
    localparam int CNT_W = $clog2(STRETCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             drive;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.drive = evt_i | (st_q.cnt != '0);
        if (evt_i)               st_d.cnt = CNT_LOAD;
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) st_q <= '{cnt: CNT_LOAD, drive: 1'b1};
        else         st_q <= st_d;
    end

    assign drive_o = st_q.drive;
endmodule

// File: rtl/rcc_cause_regs.sv
module rcc_cause_regs
    import rcc_pkg::*;
(
    input  logic               clk,
    input  logic               por_req,
    input  logic               lvr_i,
    input  logic               htr_i,
    input  logic               wdr_i,
    input  logic               ext_i,
    input  logic               busy_i,
    input  logic               we_i,
    input  logic               addr_i,
    input  logic [CAUSE_W-1:0] wdata_i,
    output logic [CAUSE_W-1:0] rdata_o,
    output logic [CAUSE_W-1:0] stat_o,
    output logic               htr_mask_o
);
    typedef struct packed {
        logic [CAUSE_W-1:0] stat;
        logic               mask;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [CAUSE_W-1:0] clr, set;

    always_comb begin
        st_d = st_q;
        clr  = (we_i && !addr_i) ? wdata_i : '0;
        set  = '0;
        set[C_LVR] = lvr_i;
        set[C_HTR] = htr_i;
        set[C_WDR] = wdr_i;
        set[C_PIN] = ext_i;
        st_d.stat  = (st_q.stat & ~clr) | set;
        if (busy_i)               st_d.mask = 1'b0;
        else if (we_i && addr_i)  st_d.mask = wdata_i[0];
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) st_q <= '{stat: CAUSE_AFTER_POR, mask: 1'b0};
        else         st_q <= st_d;
    end

    assign rdata_o    = addr_i ? CAUSE_W'(st_q.mask) : st_q.stat;
    assign stat_o     = st_q.stat;
    assign htr_mask_o = st_q.mask;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int CLK_HZ      = 16_000_000,
    parameter int STRETCH_CYC = (CLK_HZ / 800 > 0) ? CLK_HZ / 800 : 1
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               lvr_req,
    input  logic               htr_req,
    input  logic               wdr_req,
    input  logic               rst_pin_i,
    output logic               rst_pin_oe,
    output logic               bank_rst,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [CAUSE_W-1:0] reg_wdata,
    output logic [CAUSE_W-1:0] reg_rdata
);
    logic htr_mask, htr_eff, int_evt, drive, ext_q, ext_now, busy;
    logic [CAUSE_W-1:0] stat_bits;

    assign htr_eff = htr_req & ~htr_mask;
    assign int_evt = lvr_req | wdr_req | htr_eff;
    assign busy    = int_evt | ext_now | drive | ext_q;

    rcc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk(clk), .por_req(por_req), .evt_i(int_evt), .drive_o(drive)
    );

    rcc_pin_sync u_sync (
        .clk(clk), .por_req(por_req), .pin_i(rst_pin_i), .drive_i(drive),
        .ext_o(ext_q), .ext_now_o(ext_now)
    );

    rcc_cause_regs u_regs (
        .clk(clk), .por_req(por_req), .lvr_i(lvr_req), .htr_i(htr_eff),
        .wdr_i(wdr_req), .ext_i(ext_now), .busy_i(busy), .we_i(reg_we),
        .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .stat_o(stat_bits), .htr_mask_o(htr_mask)
    );

    assign rst_pin_oe = drive;
    assign bank_rst   = drive | ext_q;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
    import rcc_pkg::*;
(
    input logic               clk,
    input logic               por_req,
    input logic               lvr_req,
    input logic               htr_req,
    input logic               wdr_req,
    input logic               htr_mask,
    input logic               rst_pin_oe,
    input logic               reg_we,
    input logic               ext_q,
    input logic [CAUSE_W-1:0] stat
);
    a_r2_request_drives_pin: assert property (@(posedge clk) disable iff (por_req)
        (lvr_req || wdr_req) |=> rst_pin_oe);

    a_r3_release_only_when_idle: assert property (@(posedge clk) disable iff (por_req)
        $fell(rst_pin_oe) |-> (!$past(lvr_req) && !$past(wdr_req)));

    a_r4_masked_htr_no_flag: assert property (@(posedge clk) disable iff (por_req)
        (htr_req && htr_mask && !lvr_req && !wdr_req) |=> !$rose(stat[C_HTR]));

    a_r6_own_drive_not_external: assert property (@(posedge clk) disable iff (por_req)
        $past(rst_pin_oe) |-> !ext_q);

    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (por_req)
        !reg_we |=> ((stat & $past(stat)) == $past(stat)));
endmodule

bind rst_cause_ctrl rcc_checker u_chk (
    .clk(clk), .por_req(por_req), .lvr_req(lvr_req), .htr_req(htr_req),
    .wdr_req(wdr_req), .htr_mask(htr_mask), .rst_pin_oe(rst_pin_oe),
    .reg_we(reg_we), .ext_q(ext_q), .stat(stat_bits)
);

// File: tb/tb_rst_cause_ctrl.sv
`timescale 1ns/1ps
module tb_rst_cause_ctrl;
    localparam int S = 5;

    logic clk = 1'b0;
    logic por_req = 1'b1, lvr_req = 1'b0, htr_req = 1'b0, wdr_req = 1'b0;
    logic ext_pull = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
    logic [4:0] reg_wdata = '0;
    logic [4:0] reg_rdata;
    logic rst_pin_oe, bank_rst, rst_pin_i;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    assign rst_pin_i = ~(rst_pin_oe | ext_pull);

    rst_cause_ctrl #(.STRETCH_CYC(S)) dut (
        .clk(clk), .por_req(por_req), .lvr_req(lvr_req), .htr_req(htr_req),
        .wdr_req(wdr_req), .rst_pin_i(rst_pin_i), .rst_pin_oe(rst_pin_oe),
        .bank_rst(bank_rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input logic a, input logic [4:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic stretch_len(output int n);
        n = 0;
        for (int i = 0; i < S + 20; i++) begin
            step(1);
            if (rst_pin_oe) n++;
            else break;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v, n;
        step(3);
        // R1: reset state
        check(rst_pin_oe && bank_rst, "R1 pin/bank during por", int'(rst_pin_oe), 1);
        rd(0, v); check(v == 1, "R1 cause after por", v, 1);
        rd(1, v); check(v == 0, "R1 mask after por", v, 0);
        por_req = 1'b0;
        stretch_len(n); check(n == S, "R1 stretch after por", n, S);
        step(4);
        check(!bank_rst, "R1 bank released", int'(bank_rst), 0);
        rd(0, v); check(v == 1, "R6 no pin flag after por", v, 1);

        // R7 / R10 register access
        wr(0, 5'h00); rd(0, v); check(v == 1, "R7 zero write no effect", v, 1);
        wr(1, 5'h01); rd(1, v); check(v == 1, "R10 mask write", v, 1);
        wr(1, 5'h00); rd(1, v); check(v == 0, "R10 mask clear", v, 0);
        // R8: first non-por reset keeps por flag
        lvr_req = 1'b1; step(2); lvr_req = 1'b0;
        stretch_len(n); step(4);
        rd(0, v); check(v == 5'h03, "R8 cause kept across lvr", v, 3);
        wr(0, 5'h02); rd(0, v); check(v == 1, "R7 single bit clear", v, 1);
        wr(0, 5'h1F); rd(0, v); check(v == 0, "R7 clear all", v, 0);

        // Sweep all request combinations, mask off and on (R2 R3 R4 R8 R9)
        for (int mk = 0; mk < 2; mk++) begin
            for (int m = 0; m < 8; m++) begin
                bit l, h, w, he, eff;
                int exp;
                l = m[0]; h = m[1]; w = m[2];
                wr(1, 5'(mk)); rd(1, v);
                check(v == mk, "R10 mask readback", v, mk);
                he  = h && (mk == 0 || l || w);
                eff = l || w || he;
                exp = (l ? 2 : 0) | (he ? 4 : 0) | (w ? 8 : 0);
                lvr_req = l; htr_req = h; wdr_req = w;
                step(3);
                check(rst_pin_oe == eff, "R2 R4 pin drive", int'(rst_pin_oe), int'(eff));
                check(bank_rst == eff, "R2 R4 bank reset", int'(bank_rst), int'(eff));
                rd(0, v); check(v == exp, "R9 R4 cause flags", v, exp);
                lvr_req = 0; htr_req = 0; wdr_req = 0;
                stretch_len(n);
                check(n == (eff ? S : 0), "R3 stretch length", n, eff ? S : 0);
                step(4);
                rd(0, v); check(v == exp, "R6 no own pin flag", v, exp);
                rd(1, v);
                check(v == (eff ? 0 : mk), "R8 mask after reset", v, eff ? 0 : mk);
                wr(0, 5'h1F); rd(0, v); check(v == 0, "R7 clear", v, 0);
            end
        end

        // R3 overlapping requests
        lvr_req = 1; step(3); wdr_req = 1; step(1); lvr_req = 0; step(2); wdr_req = 0;
        stretch_len(n); check(n == S, "R3 overlap stretch", n, S);
        // R3 retrigger during stretch
        wdr_req = 1; step(1); wdr_req = 0; step(2); wdr_req = 1; step(1); wdr_req = 0;
        stretch_len(n); check(n == S, "R3 retrigger stretch", n, S);
        step(4); wr(0, 5'h1F);

        // R5 external pin reset
        wr(1, 5'h01);
        ext_pull = 1; step(2);
        check(!bank_rst, "R5 bank before sync", int'(bank_rst), 0);
        step(1);
        check(bank_rst, "R5 bank after three edges", int'(bank_rst), 1);
        check(!rst_pin_oe, "R5 no pin drive", int'(rst_pin_oe), 0);
        rd(0, v); check(v == 5'h10, "R5 pin flag", v, 16);
        ext_pull = 0; step(4);
        check(!bank_rst, "R5 bank released", int'(bank_rst), 0);
        rd(1, v); check(v == 0, "R8 mask cleared by pin reset", v, 0);

        // R1 por clears everything again
        wdr_req = 1; step(1); wdr_req = 0; step(1);
        por_req = 1; step(2);
        rd(0, v); check(v == 1, "R1 por clears cause", v, 1);
        por_req = 0;
        stretch_len(n); check(n == S, "R1 stretch after second por", n, S);
        finish_run();
    end
endmodule